// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a single-clock static RAM with registered inputs and a registered read path, meant for cache and buffer storage inside a larger design. Every control, address and write-data input is taken on the rising clock edge. A read address taken on one edge produces its word on the data output after the next edge. Writes land in the array on the same edge that captures them. Each write either covers the whole word through a global write strobe or only the byte lanes picked by per-lane enables, which a master byte-write enable gates. Each lane can carry one parity bit, which is stored and returned with its byte.

An access opens when one of two address strobes is asserted and all three chip enables agree. Later cycles without a strobe continue the access. A 2-bit burst counter steps the low address bits in linear or interleaved order, or holds the address when advance is not asserted. When the device is deselected, the output stays driven for one extra cycle so that a read already in flight completes cleanly. The common data bus leaves the block as a data-in, data-out and drive-enable trio for the pad ring. An asynchronous active-low output enable and a sleep input can both release it at once. Sleep also freezes all internal state and keeps the stored contents.

Top module: `sync_burst_sram`

## Requirements
- R1: A new access opens only when sel_n_i=0, sel_i=1 and sel2_n_i=0 on a strobe cycle. A strobe cycle with any enable off is a deselect: nothing is written, no read data is driven, and the open burst is closed.
- R2: A read captured on edge k gives dq_oe_o=1 and the addressed word on dq_o after edge k+1, provided oe_n_i=0 and sleep_i=0.
- R3: After the last read, a following non-write cycle keeps dq_oe_o=1 with the same word for one extra cycle (read on edge k, deselect on edge k+1, still driven after k+2, released after k+3). A write cycle right after a read releases the bus after its own edge, with no extra cycle.
- R4: wr_all_n_i=0 on a write-capable cycle writes all lanes, whatever wr_byte_n_i and wr_lane_n_i say.
- R5: With wr_all_n_i=1 and wr_byte_n_i=0, exactly the lanes l with wr_lane_n_i[l]=0 are written. Lane l is word bits [l*(8+PARITY) +: 8+PARITY], and its top bit is the parity bit when PARITY=1. With wr_byte_n_i=1 (and wr_all_n_i=1) the cycle is a read.
- R6: A processor strobe (strobe_p_n_i=0 with sel_n_i=0) always opens a read and ignores the write inputs. With sel_n_i=1 the processor strobe is ignored and the cycle continues the open burst.
- R7: Continuation cycles (both strobes high) with adv_n_i=0 step a 2-bit count k from 0. The low two address bits become (base+k) mod 4 when order_lin_i=1, or base XOR k when order_lin_i=0. The upper bits stay fixed, and the count wraps after four.
- R8: A continuation cycle with adv_n_i=1 repeats the current address.
- R9: oe_n_i=1 forces dq_oe_o=0 at once, with no clock edge. Returning it to 0 restores the drive if a read word is still held.
- R10: While sleep_i=1, dq_oe_o=0, no write occurs, and the read pipeline and burst state hold. After sleep_i returns to 0, operation resumes from the frozen state with the contents unchanged.
- R11: A read on the cycle right after a write to the same address returns the newly written word.
- R12: Synchronous active-high rst clears the read pipeline and closes any burst: dq_oe_o=0, and continuation cycles after reset neither read nor drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sleep_i | input | 1 | Sleep: freezes state, releases bus |
| addr_i | input | AW | Word address |
| sel_n_i | input | 1 | Primary chip enable, active low |
| sel_i | input | 1 | Chip enable, active high |
| sel2_n_i | input | 1 | Secondary chip enable, active low |
| strobe_p_n_i | input | 1 | Processor address strobe, active low |
| strobe_c_n_i | input | 1 | Controller address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| order_lin_i | input | 1 | Burst order: 1 linear, 0 interleaved |
| wr_all_n_i | input | 1 | Global write, active low |
| wr_byte_n_i | input | 1 | Byte-write master enable, active low |
| wr_lane_n_i | input | LANES | Per-lane write enables, active low |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| dq_i | input | LANES*(8+PARITY) | Write data from the bus |
| dq_o | output | LANES*(8+PARITY) | Read data to the bus |
| dq_oe_o | output | 1 | Bus drive enable for the pad |

## Verification
The bench builds the block with AW=4, LANES=4 and PARITY=1: a 16-word array of 36-bit words with four 9-bit lanes. At that size every address can be filled and read back, all sixteen lane-enable patterns can be applied to one word with the parity bits included, and every starting offset can be driven through a full wrapping burst in both orders. The deselect window, output-enable release, sleep freeze and strobe priority are then checked at exact cycle positions against a model memory held in the bench.

// File: rtl/psb_pkg.sv
package psb_pkg;

  typedef enum logic [1:0] {
    OP_NOP   = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // low address bits of burst step k from start offset b
  function automatic logic [1:0] burst_lsb(input logic [1:0] b,
                                           input logic [1:0] k,
                                           input logic       lin);
    return lin ? (b + k) : (b ^ k);
  endfunction

endpackage

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
  import psb_pkg::*;
#(
  parameter int AW    = 10,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             sel_n_i,
  input  logic             sel_i,
  input  logic             sel2_n_i,
  input  logic             strobe_p_n_i,
  input  logic             strobe_c_n_i,
  input  logic             adv_n_i,
  input  logic             order_lin_i,
  input  logic             wr_all_n_i,
  input  logic             wr_byte_n_i,
  input  logic [LANES-1:0] wr_lane_n_i,
  output logic [AW-1:0]    acc_addr_o,
  output logic [LANES-1:0] lane_we_o,
  output op_e              op_q_o
);

  logic             live_q, live_nxt;
  logic [AW-1:0]    base_q, base_nxt;
  logic [1:0]       step_q, step_nxt;
  op_e              op_q, op_nxt;
  logic             chip_on, start_p, start_c, start;
  logic [LANES-1:0] lane_req;
  logic             wr_req;

  always_comb begin
    chip_on  = !sel_n_i && sel_i && !sel2_n_i;
    start_p  = !strobe_p_n_i && !sel_n_i;
    start_c  = !strobe_c_n_i;
    start    = start_p || start_c;
    if (!wr_all_n_i)       lane_req = '1;
    else if (!wr_byte_n_i) lane_req = ~wr_lane_n_i;
    else                   lane_req = '0;
    wr_req   = |lane_req;

    live_nxt = live_q;
    base_nxt = base_q;
    step_nxt = adv_n_i ? step_q : step_q + 2'd1;
    op_nxt   = OP_NOP;

    if (start) begin
      step_nxt = 2'd0;
      if (chip_on) begin
        live_nxt = 1'b1;
        base_nxt = addr_i;
        op_nxt   = (start_c && !start_p && wr_req) ? OP_WRITE : OP_READ;
      end else begin
        live_nxt = 1'b0;
      end
    end else if (live_q) begin
      op_nxt = wr_req ? OP_WRITE : OP_READ;
    end

    acc_addr_o = {base_nxt[AW-1:2], burst_lsb(base_nxt[1:0], step_nxt, order_lin_i)};
    lane_we_o  = (op_nxt == OP_WRITE && !sleep_i) ? lane_req : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= 1'b0;
      base_q <= '0;
      step_q <= '0;
      op_q   <= OP_NOP;
    end else if (!sleep_i) begin
      live_q <= live_nxt;
      base_q <= base_nxt;
      step_q <= step_nxt;
      op_q   <= op_nxt;
    end
  end

  assign op_q_o = op_q;

  // burst start address must hold across continuation cycles
  AST_BASE_HELD: assert property (@(posedge clk) disable iff (rst)
    (!start && !sleep_i) |=> $stable(base_q)); // R7

  // a closed burst issues no operation on continuation cycles
  AST_CLOSED_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!live_q && !start && !sleep_i) |=> (op_q == OP_NOP)); // R12

endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
  parameter int AW     = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    run_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [LANES-1:0]        we_i,
  input  logic [LANES*LANE_W-1:0] wd_i,
  output logic [LANES*LANE_W-1:0] rd_o
);

  localparam int DEPTH = 1 << AW;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] lane_q;

    always_ff @(posedge clk) begin
      if (we_i[l]) mem[addr_i] <= wd_i[l*LANE_W +: LANE_W];
      if (run_i)   lane_q      <= mem[addr_i];
    end

    assign rd_o[l*LANE_W +: LANE_W] = lane_q;
  end

endmodule

// File: rtl/sbs_outpipe.sv
module sbs_outpipe
  import psb_pkg::*;
#(
  parameter int W = 36
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run_i,
  input  op_e          op_i,
  input  logic [W-1:0] rd_i,
  output logic [W-1:0] dq_o,
  output logic         drv_o
);

  logic [W-1:0] out_q;
  logic         drv_q;
  logic         ext_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
      drv_q <= 1'b0;
      ext_q <= 1'b0;
    end else if (run_i) begin
      unique case (op_i)
        OP_READ: begin
          out_q <= rd_i;
          drv_q <= 1'b1;
          ext_q <= 1'b0;
        end
        OP_WRITE: begin
          drv_q <= 1'b0;
          ext_q <= 1'b0;
        end
        default: begin
          if (drv_q && !ext_q) begin
            ext_q <= 1'b1;
          end else begin
            drv_q <= 1'b0;
            ext_q <= 1'b0;
          end
        end
      endcase
    end
  end

  assign dq_o  = out_q;
  assign drv_o = drv_q;

  // the deselect extension never lasts past one cycle
  AST_EXT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (run_i && ext_q) |=> !ext_q); // R3

  // drive can only start from a read taken by the control stage
  AST_DRV_FROM_READ: assert property (@(posedge clk) disable iff (rst)
    $rose(drv_q) |-> ($past(op_i) == OP_READ)); // R2

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import psb_pkg::*;
#(
  parameter int AW     = 10,
  parameter int LANES  = 4,
  parameter int PARITY = 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           sleep_i,
  input  logic [AW-1:0]                  addr_i,
  input  logic                           sel_n_i,
  input  logic                           sel_i,
  input  logic                           sel2_n_i,
  input  logic                           strobe_p_n_i,
  input  logic                           strobe_c_n_i,
  input  logic                           adv_n_i,
  input  logic                           order_lin_i,
  input  logic                           wr_all_n_i,
  input  logic                           wr_byte_n_i,
  input  logic [LANES-1:0]               wr_lane_n_i,
  input  logic                           oe_n_i,
  input  logic [LANES*(8+PARITY)-1:0]    dq_i,
  output logic [LANES*(8+PARITY)-1:0]    dq_o,
  output logic                           dq_oe_o
);

  localparam int LW = 8 + PARITY;
  localparam int W  = LANES * LW;

  logic [AW-1:0]    acc_addr;
  logic [LANES-1:0] lane_we;
  op_e              op_q;
  logic [W-1:0]     rd_word;
  logic             drv;
  logic             run;

  assign run = !sleep_i;

  sbs_ctrl #(.AW(AW), .LANES(LANES)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .sleep_i      (sleep_i),
    .addr_i       (addr_i),
    .sel_n_i      (sel_n_i),
    .sel_i        (sel_i),
    .sel2_n_i     (sel2_n_i),
    .strobe_p_n_i (strobe_p_n_i),
    .strobe_c_n_i (strobe_c_n_i),
    .adv_n_i      (adv_n_i),
    .order_lin_i  (order_lin_i),
    .wr_all_n_i   (wr_all_n_i),
    .wr_byte_n_i  (wr_byte_n_i),
    .wr_lane_n_i  (wr_lane_n_i),
    .acc_addr_o   (acc_addr),
    .lane_we_o    (lane_we),
    .op_q_o       (op_q)
  );

  sbs_array #(.AW(AW), .LANES(LANES), .LANE_W(LW)) u_array (
    .clk    (clk),
    .run_i  (run),
    .addr_i (acc_addr),
    .we_i   (lane_we),
    .wd_i   (dq_i),
    .rd_o   (rd_word)
  );

  sbs_outpipe #(.W(W)) u_out (
    .clk   (clk),
    .rst   (rst),
    .run_i (run),
    .op_i  (op_q),
    .rd_i  (rd_word),
    .dq_o  (dq_o),
    .drv_o (drv)
  );

  assign dq_oe_o = drv && !oe_n_i && !sleep_i;

  AST_SLEEP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    sleep_i |-> (lane_we == '0)); // R10

  AST_GLOBAL_ALL_LANES: assert property (@(posedge clk) disable iff (rst)
    (!sleep_i && !wr_all_n_i && (lane_we != '0)) |-> (&lane_we)); // R4

  AST_PSTROBE_READS: assert property (@(posedge clk) disable iff (rst)
    (!strobe_p_n_i && !sel_n_i) |-> (lane_we == '0)); // R6

  AST_DESEL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!strobe_c_n_i && !sel_i) |-> (lane_we == '0)); // R1

endmodule

// File: tb/sim_sync_burst_sram.sv
module sim_sync_burst_sram;
  localparam int AW = 4, LANES = 4, PARITY = 1;
  localparam int LW = 8 + PARITY, W = LANES * LW, N = 1 << AW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, sleep, sel_n, sel, sel2_n, sp_n, sc_n, adv_n, lin, wa_n, wb_n, oe_n;
  logic [AW-1:0]    addr;
  logic [LANES-1:0] wl_n;
  logic [W-1:0]     dq_i, dq_o;
  logic             dq_oe;

  sync_burst_sram #(.AW(AW), .LANES(LANES), .PARITY(PARITY)) u0 (
    .clk(clk), .rst(rst), .sleep_i(sleep), .addr_i(addr),
    .sel_n_i(sel_n), .sel_i(sel), .sel2_n_i(sel2_n),
    .strobe_p_n_i(sp_n), .strobe_c_n_i(sc_n), .adv_n_i(adv_n),
    .order_lin_i(lin), .wr_all_n_i(wa_n), .wr_byte_n_i(wb_n),
    .wr_lane_n_i(wl_n), .oe_n_i(oe_n), .dq_i(dq_i), .dq_o(dq_o),
    .dq_oe_o(dq_oe)
  );

  logic [W-1:0] mdl [N];
  int  total = 0, bad = 0;
  bit  done = 1'b0;

  function automatic logic [W-1:0] fdat(input int a, input int s);
    return W'(64'(a) * 64'h1357_9BDF + 64'(s) * 64'h9_8765_4321 + 64'h5A5);
  endfunction

  task automatic tick; @(posedge clk); #2; endtask

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic quiet;
    sp_n = 1; sc_n = 1; adv_n = 1; wa_n = 1; wb_n = 1; wl_n = '1;
    sel_n = 1; sel = 0; sel2_n = 1;
  endtask

  task automatic chip_on; sel_n = 0; sel = 1; sel2_n = 0; endtask

  task automatic cyc_desel; quiet; sc_n = 0; tick; endtask

  task automatic cyc_read(input int a);
    quiet; chip_on; sc_n = 0; addr = AW'(a); tick;
  endtask

  task automatic cyc_write(input int a, input logic [W-1:0] d, input logic ga_n,
                           input logic be_n, input logic [LANES-1:0] ln);
    quiet; chip_on; sc_n = 0; addr = AW'(a); dq_i = d;
    wa_n = ga_n; wb_n = be_n; wl_n = ln; tick;
  endtask

  task automatic cyc_cont(input logic adv); quiet; adv_n = adv; tick; endtask

  task automatic rd_chk(input int a, input string tag);
    cyc_read(a); cyc_desel;
    chk(dq_oe && dq_o == mdl[a], tag, dq_o, mdl[a]);
    cyc_desel; cyc_desel;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    quiet; rst = 1; sleep = 0; lin = 1; oe_n = 0; addr = '0; dq_i = '0;
    repeat (3) tick;
    rst = 0;
    chk(!dq_oe, "R12 reset releases bus", W'(dq_oe), '0);
    cyc_cont(0); cyc_cont(0);
    chk(!dq_oe, "R12 no burst after reset", W'(dq_oe), '0);

    // R4: global write with lane and master enables all off
    for (int a = 0; a < N; a++) begin
      mdl[a] = fdat(a, 0);
      cyc_write(a, mdl[a], 1'b0, 1'b1, '1);
    end
    // R2 / R3: read each word, check latency and the double-cycle release
    for (int a = 0; a < N; a++) begin
      cyc_read(a); cyc_desel;
      chk(dq_oe && dq_o == mdl[a], "R2 R4 read after one edge", dq_o, mdl[a]);
      cyc_desel;
      chk(dq_oe && dq_o == mdl[a], "R3 extra driven cycle", dq_o, mdl[a]);
      cyc_desel;
      chk(!dq_oe, "R3 released after extension", W'(dq_oe), '0);
    end

    // R3: a write after a read releases without the extra cycle
    cyc_read(2);
    cyc_write(15, mdl[15], 1'b0, 1'b1, '1);
    chk(dq_oe && dq_o == mdl[2], "R3 read before write", dq_o, mdl[2]);
    cyc_desel;
    chk(!dq_oe, "R3 write releases at once", W'(dq_oe), '0);
    cyc_desel;

    // R5 / R11: every lane mask on one word, read right after the write
    for (int m = 0; m < 16; m++) begin
      logic [W-1:0] d;
      d = fdat(5, m + 1);
      for (int l = 0; l < LANES; l++)
        if (m[l]) mdl[5][l*LW +: LW] = d[l*LW +: LW];
      cyc_write(5, d, 1'b1, 1'b0, ~LANES'(m));
      cyc_read(5); cyc_desel;
      chk(dq_oe && dq_o == mdl[5], "R5 R11 lane mask write then read", dq_o, mdl[5]);
      cyc_desel; cyc_desel;
    end
    // R5: lane enables without the master enable do not write
    cyc_write(6, ~mdl[6], 1'b1, 1'b1, '0);
    cyc_desel; cyc_desel;
    rd_chk(6, "R5 master enable off ignored");

    // R1: any chip enable off blocks the write and the read
    quiet; chip_on; sel = 0; sc_n = 0; addr = 4'd9; dq_i = ~mdl[9]; wa_n = 0; tick;
    quiet; chip_on; sel2_n = 1; sc_n = 0; addr = 4'd9; tick;
    cyc_desel;
    chk(!dq_oe, "R1 deselected read not driven", W'(dq_oe), '0);
    cyc_desel;
    rd_chk(9, "R1 deselected write ignored");

    // R6: processor strobe ignores write inputs
    quiet; chip_on; sp_n = 0; addr = 4'd10; dq_i = ~mdl[10]; wa_n = 0; tick;
    cyc_desel;
    chk(dq_oe && dq_o == mdl[10], "R6 processor strobe reads", dq_o, mdl[10]);
    cyc_desel; cyc_desel;
    rd_chk(10, "R6 processor strobe did not write");
    // R6: processor strobe with primary enable off continues the burst
    lin = 1;
    cyc_read(8);
    quiet; sp_n = 0; sel_n = 1; adv_n = 0; tick;
    chk(dq_oe && dq_o == mdl[8], "R6 burst first word", dq_o, mdl[8]);
    cyc_desel;
    chk(dq_oe && dq_o == mdl[9], "R6 ignored strobe advanced burst", dq_o, mdl[9]);
    cyc_desel; cyc_desel;

    // R7: all start offsets, both orders, through the wrap
    for (int o = 0; o < 2; o++) begin
      for (int b = 0; b < 4; b++) begin
        int hi;
        int seq [5];
        hi = (b + 1 + o) % 4;
        lin = o[0];
        for (int i = 0; i < 5; i++)
          seq[i] = hi * 4 + (o == 1 ? (b + i) % 4 : (b ^ (i % 4)));
        cyc_read(seq[0]);
        for (int i = 1; i < 5; i++) begin
          cyc_cont(0);
          chk(dq_oe && dq_o == mdl[seq[i-1]], "R7 burst order", dq_o, mdl[seq[i-1]]);
        end
        cyc_desel;
        chk(dq_oe && dq_o == mdl[seq[4]], "R7 burst wrap", dq_o, mdl[seq[4]]);
        cyc_desel; cyc_desel;
      end
    end

    // R8: advance off repeats the address
    lin = 1;
    cyc_read(3);
    cyc_cont(1);
    chk(dq_oe && dq_o == mdl[3], "R8 first word", dq_o, mdl[3]);
    cyc_cont(0);
    chk(dq_oe && dq_o == mdl[3], "R8 held address", dq_o, mdl[3]);
    cyc_desel;
    chk(dq_oe && dq_o == mdl[0], "R8 advance after hold", dq_o, mdl[0]);
    cyc_desel; cyc_desel;

    // R9: output enable acts without a clock edge
    cyc_read(4); cyc_desel;
    oe_n = 1; #1;
    chk(!dq_oe, "R9 output enable off", W'(dq_oe), '0);
    oe_n = 0; #1;
    chk(dq_oe && dq_o == mdl[4], "R9 output enable back on", dq_o, mdl[4]);
    cyc_desel; cyc_desel;

    // R10: sleep freezes the pipeline and blocks writes
    cyc_read(7);
    sleep = 1;
    quiet; chip_on; sc_n = 0; addr = 4'd7; dq_i = ~mdl[7]; wa_n = 0; tick;
    chk(!dq_oe, "R10 bus off in sleep", W'(dq_oe), '0);
    tick;
    chk(!dq_oe, "R10 bus off in sleep again", W'(dq_oe), '0);
    quiet; sc_n = 0; sleep = 0; tick;
    chk(dq_oe && dq_o == mdl[7], "R10 pipeline resumes", dq_o, mdl[7]);
    cyc_desel; cyc_desel;
    rd_chk(7, "R10 contents kept");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule